// File: doc/BRIEF.md
# Phase-Adjustable Integer Clock Divider

This block turns a fast input clock into a one-cycle clock-enable pulse, `div_tick`, that repeats every N input cycles, with N programmable from 1 to 8. A second field of the same configuration byte shifts the pulse train by a whole number of input cycles (0 to 7) relative to a synchronisation event. Logic downstream runs on the input clock and qualifies its work with `div_tick`. The block also raises `stab_req`, which turns on the duty-cycle stabilizer when the global stabilizer bit is set and also whenever a division other than 1 is programmed.

Inside, a two-state machine moves between `ST_COUNT` (the divider counter runs, and `div_tick` is high when the counter is zero) and `ST_ALIGN` (a phase countdown runs and `div_tick` stays low). Its transitions are:
- **SYNC_HIT**: an accepted sync goes to `ST_ALIGN`, or to `ST_COUNT` when the offset is zero or the ratio is 1.
- **WRAP_PLAIN**: a counter wrap with no phase change stays in `ST_COUNT`.
- **WRAP_SHIFT**: a counter wrap with a phase change goes to `ST_ALIGN`.
- **ALIGN_STEP**: the countdown decrements while staying in `ST_ALIGN`.
- **ALIGN_DONE**: the countdown reaches 1 and the machine returns to `ST_COUNT` with the counter at zero.

A sync gate decides which sync pulses are accepted. In one-shot mode it accepts a single pulse and then blocks further pulses.

Top module: `clkdiv_phase_top`

## Requirements
- R1: After reset, with the configuration byte at 0x00, `div_tick` is high in every input cycle.
- R2: Bits 2:0 of `cfg_byte` hold a ratio code c. When c is not 0, `div_tick` is a one-cycle pulse that repeats every c+1 input cycles.
- R3: Bits 5:3 of `cfg_byte` hold a phase code p (plain binary). When a sync is sampled at a clock edge and c is not 0, the first pulse appears in the cycle that starts p edges after that edge.
- R4: When c is 0, `div_tick` stays high continuously and p has no effect.
- R5: `stab_req` is high when `stab_global` is high or c is not 0, and low otherwise.
- R6: A new ratio code written while the divider runs takes effect at the next counter wrap. The current period always completes.
- R7: A new phase code written while the divider runs takes effect at the next counter wrap. When the new ratio is not 1, it inserts (p_new − p_old) mod 8 idle cycles before the next pulse.
- R8: While `sync_en` is low, `sync_in` has no effect on `div_tick`.
- R9: While `sync_once` is high, only the first accepted sync realigns the divider; later syncs are ignored until `sync_once` goes low.
- R10: Bits 7:6 of `cfg_byte` have no effect on `div_tick` or `stab_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte | input | 8 | Configuration: [2:0] ratio code, [5:3] phase code, [7:6] spare |
| stab_global | input | 1 | Global stabilizer enable bit |
| sync_in | input | 1 | Realignment request, sampled each edge |
| sync_en | input | 1 | Allows `sync_in` to be accepted |
| sync_once | input | 1 | One-shot sync mode |
| div_tick | output | 1 | Divided clock-enable pulse |
| stab_req | output | 1 | Stabilizer request |

## Verification
The bench builds the block with its default 3-bit ratio and phase fields. Under this default, all 64 combinations of ratio and phase can be swept from one table, with the period and the offset after sync measured for each. Directed traces then change the configuration in the middle of a period, which exercises both kinds of wrap: with and without a phase change. Further traces show that syncs are gated and that one-shot mode blocks a second sync.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_ALIGN = 1'b1
    } div_state_e;
endpackage

// File: rtl/clkdiv_cfg_decode.sv
module clkdiv_cfg_decode #(
    parameter int RATIO_W = 3,
    parameter int PHASE_W = 3
) (
    input  logic [RATIO_W+PHASE_W+1:0] cfg_byte,
    input  logic                       stab_global,
    output logic [RATIO_W-1:0]         ratio_code,
    output logic [PHASE_W-1:0]         phase_code,
    output logic                       stab_req
);
    // The two spare bits above the phase field are deliberately not decoded.
    assign ratio_code = cfg_byte[RATIO_W-1:0];
    assign phase_code = cfg_byte[RATIO_W +: PHASE_W];
    assign stab_req   = stab_global | (|ratio_code);
endmodule

// File: rtl/clkdiv_sync_gate.sv
module clkdiv_sync_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic sync_en,
    input  logic sync_once,
    output logic sync_take
);
    logic consumed_q;

    assign sync_take = sync_in & sync_en & (~sync_once | ~consumed_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            consumed_q <= 1'b0;
        end else begin
            consumed_q <= sync_once & (consumed_q | sync_take);
        end
    end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 3,
    parameter int PHASE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_code,
    input  logic [PHASE_W-1:0] phase_code,
    input  logic               sync_take,
    output logic               div_tick,
    output logic [RATIO_W-1:0] ratio_live
);
    localparam logic [PHASE_W-1:0] DLY_ONE = PHASE_W'(1);

    div_state_e         state_q, state_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] ratio_q, ratio_n;
    logic [PHASE_W-1:0] phase_q, phase_n;
    logic [PHASE_W-1:0] dly_q, dly_n;
    logic [PHASE_W-1:0] phase_step;

    assign phase_step = phase_code - phase_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
            ratio_q <= '0;
            phase_q <= '0;
            dly_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            ratio_q <= ratio_n;
            phase_q <= phase_n;
            dly_q   <= dly_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        ratio_n = ratio_q;
        phase_n = phase_q;
        dly_n   = dly_q;
        if (sync_take) begin
            // SYNC_HIT
            ratio_n = ratio_code;
            phase_n = phase_code;
            cnt_n   = '0;
            dly_n   = phase_code;
            if ((|ratio_code) && (|phase_code)) begin
                state_n = ST_ALIGN;
            end else begin
                state_n = ST_COUNT;
            end
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (cnt_q == ratio_q) begin
                        cnt_n   = '0;
                        ratio_n = ratio_code;
                        phase_n = phase_code;
                        if ((|ratio_code) && (|phase_step)) begin
                            // WRAP_SHIFT
                            state_n = ST_ALIGN;
                            dly_n   = phase_step;
                        end
                        // otherwise WRAP_PLAIN
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_ALIGN: begin
                    if (dly_q == DLY_ONE) begin
                        // ALIGN_DONE
                        state_n = ST_COUNT;
                        cnt_n   = '0;
                    end else begin
                        // ALIGN_STEP
                        dly_n = dly_q - 1'b1;
                    end
                end
                default: state_n = ST_COUNT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        div_tick   = (state_q == ST_COUNT) && (cnt_q == '0);
        ratio_live = ratio_q;
    end
endmodule

// File: rtl/clkdiv_phase_top.sv
module clkdiv_phase_top #(
    parameter int RATIO_W = 3,
    parameter int PHASE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [RATIO_W+PHASE_W+1:0] cfg_byte,
    input  logic                       stab_global,
    input  logic                       sync_in,
    input  logic                       sync_en,
    input  logic                       sync_once,
    output logic                       div_tick,
    output logic                       stab_req
);
    logic [RATIO_W-1:0] ratio_code;
    logic [PHASE_W-1:0] phase_code;
    logic [RATIO_W-1:0] ratio_live;
    logic               sync_take;

    clkdiv_cfg_decode #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_decode (
        .cfg_byte    (cfg_byte),
        .stab_global (stab_global),
        .ratio_code  (ratio_code),
        .phase_code  (phase_code),
        .stab_req    (stab_req)
    );

    clkdiv_sync_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .sync_en   (sync_en),
        .sync_once (sync_once),
        .sync_take (sync_take)
    );

    clkdiv_core #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .phase_code (phase_code),
        .sync_take  (sync_take),
        .div_tick   (div_tick),
        .ratio_live (ratio_live)
    );
endmodule

// File: rtl/clkdiv_phase_chk.sv
module clkdiv_phase_chk #(
    parameter int RATIO_W = 3,
    parameter int PHASE_W = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [RATIO_W+PHASE_W+1:0] cfg_byte,
    input logic                       stab_global,
    input logic                       sync_en,
    input logic                       sync_once,
    input logic                       sync_take,
    input logic [RATIO_W-1:0]         ratio_live,
    input logic                       div_tick,
    input logic                       stab_req
);
    // R5
    stab_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_byte[RATIO_W-1:0]) |-> stab_req);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && (ratio_live != '0) && !sync_take) |=> !div_tick);

    // R3
    sync_zero_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_take && (|cfg_byte[RATIO_W-1:0]) && !(|cfg_byte[RATIO_W +: PHASE_W]))
        |=> div_tick);

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_take && (|cfg_byte[RATIO_W-1:0]) && (|cfg_byte[RATIO_W +: PHASE_W]))
        |=> !div_tick);

    // R8
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en |-> !sync_take);

    // R9
    sync_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_take && sync_once) |=> (!sync_once || !sync_take));

    // R4
    unity_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ratio_live == '0) && $past(ratio_live == '0) && $past(div_tick)) |-> div_tick);
endmodule

bind clkdiv_phase_top clkdiv_phase_chk #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_byte    (cfg_byte),
    .stab_global (stab_global),
    .sync_en     (sync_en),
    .sync_once   (sync_once),
    .sync_take   (sync_take),
    .ratio_live  (ratio_live),
    .div_tick    (div_tick),
    .stab_req    (stab_req)
);

// File: tb/test_clkdiv_phase_top.sv
`timescale 1ns/1ps
module test_clkdiv_phase_top;
    typedef logic [7:0] vec_t [64];

    function automatic vec_t build_vecs();
        vec_t v;
        for (int i = 0; i < 64; i++) begin
            v[i] = 8'(((i % 4) << 6) | i); // spare bits vary too (R10)
        end
        return v;
    endfunction

    localparam vec_t VECS = build_vecs();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_byte = 8'h00;
    logic       stab_global = 1'b1;
    logic       sync_in = 1'b0;
    logic       sync_en = 1'b1;
    logic       sync_once = 1'b0;
    logic       div_tick;
    logic       stab_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clkdiv_phase_top i_clkdiv_phase_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_byte    (cfg_byte),
        .stab_global (stab_global),
        .sync_in     (sync_in),
        .sync_en     (sync_en),
        .sync_once   (sync_once),
        .div_tick    (div_tick),
        .stab_req    (stab_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Sync with cfg c0, then record the first three pulse indices k (k = 0 is the
    // cycle right after the sync edge). Optionally change cfg at chg_k and send a
    // mid-trace sync at syn_k with sync_en = mid_en.
    task automatic run_trace(input logic [7:0] c0, input int chg_k, input logic [7:0] c1,
                             input int syn_k, input logic mid_en, input logic once,
                             output int t0, output int t1, output int t2);
        int n = 0;
        t0 = -1; t1 = -1; t2 = -1;
        @(negedge clk);
        cfg_byte = c0; sync_en = 1'b1; sync_once = once; sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0; sync_en = mid_en;
        for (int k = 0; k < 40; k++) begin
            if (div_tick) begin
                if (n == 0) t0 = k;
                else if (n == 1) t1 = k;
                else if (n == 2) t2 = k;
                n++;
            end
            if (k == chg_k) cfg_byte = c1;
            sync_in = (k == syn_k);
            @(negedge clk);
        end
        sync_in = 1'b0; sync_en = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a0, a1, a2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state ticks every cycle
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(div_tick == 1'b1, "R1 tick after reset", int'(div_tick), 1);
        end
        // R5: stabilizer request
        stab_global = 1'b0; cfg_byte = 8'h00; #1;
        check(stab_req == 1'b0, "R5 stab off", int'(stab_req), 0);
        stab_global = 1'b1; #1;
        check(stab_req == 1'b1, "R5 stab global", int'(stab_req), 1);
        stab_global = 1'b0; cfg_byte = 8'h05; #1;
        check(stab_req == 1'b1, "R5 stab forced", int'(stab_req), 1);
        cfg_byte = 8'hC0; #1;
        check(stab_req == 1'b0, "R10 spare bits vs stab", int'(stab_req), 0);
        cfg_byte = 8'h00;

        // Table sweep: R2, R3, R4, R10
        for (int i = 0; i < 64; i++) begin
            int n, p, e0;
            n = (VECS[i] & 7) + 1;
            p = (VECS[i] >> 3) & 7;
            e0 = (n == 1) ? 0 : p;
            run_trace(VECS[i], -1, VECS[i], -1, 1'b1, 1'b0, a0, a1, a2);
            check(a0 == e0, (n == 1) ? "R4 first pulse" : "R3 phase offset", a0, e0);
            check(a1 - a0 == n, (n == 1) ? "R4 continuous" : "R2 period", a1 - a0, n);
            check(a2 - a1 == n, "R2 R10 period repeat", a2 - a1, n);
        end

        // R6: ratio 4 -> 2 mid-period
        run_trace(8'h03, 1, 8'h01, -1, 1'b1, 1'b0, a0, a1, a2);
        check(a1 == 4, "R6 old period completes", a1, 4);
        check(a2 == 6, "R6 new period at wrap", a2, 6);
        // R7: phase 0 -> 2 mid-period, ratio 4
        run_trace(8'h03, 1, 8'h13, -1, 1'b1, 1'b0, a0, a1, a2);
        check(a1 == 6, "R7 phase shift inserted", a1, 6);
        check(a2 == 10, "R7 period after shift", a2, 10);
        // R8: gated sync ignored
        run_trace(8'h03, -1, 8'h03, 1, 1'b0, 1'b0, a0, a1, a2);
        check(a1 == 4, "R8 gated sync ignored", a1, 4);
        // R8 control: enabled sync realigns
        run_trace(8'h03, -1, 8'h03, 1, 1'b1, 1'b0, a0, a1, a2);
        check(a1 == 2, "R8 enabled sync realigns", a1, 2);
        // R9: one-shot blocks second sync
        run_trace(8'h03, -1, 8'h03, 1, 1'b1, 1'b1, a0, a1, a2);
        check(a0 == 0, "R9 first sync accepted", a0, 0);
        check(a1 == 4, "R9 second sync blocked", a1, 4);
        // R9: releasing one-shot re-enables sync
        run_trace(8'h03, -1, 8'h03, 1, 1'b1, 1'b0, a0, a1, a2);
        check(a1 == 2, "R9 rearmed after release", a1, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule